// File: doc/BRIEF.md
# DRAM rank boundary decoder

This block holds the rank boundary registers of a two-channel memory controller with four ranks per channel and turns a physical address into a rank chip select. Each register holds a cumulative upper boundary in 64 MB units. The entry for rank N is the total size of ranks 0 through N of that channel. The decoder takes the address's 64 MB unit index, which is the address from bit 26 upward. It picks the first rank whose window contains that index. The window of a rank runs from the boundary of the rank below (zero for rank 0) up to its own boundary.

Firmware programs the boundaries through a small offset-addressed register port. It then raises a lock input, after which the boundaries are frozen until reset. Channels are selected per access by a channel input. The result is a one-hot chip select, or a miss flag when the address lies in no rank, registered one clock after the address is presented.

Top module: `rank_bound_dec`

## Requirements
- R1: After reset every boundary register reads 0x0000, `cs` is all zero and `miss` is 1.
- R2: Channel 0 registers for ranks 0 to 3 sit at offsets 0x200, 0x202, 0x204 and 0x206. Channel 1 registers sit at 0x600, 0x602, 0x604 and 0x606. Bits 9:0 of each hold the boundary and are written and read back through `wr_data` and `rd_data`, with `rd_data` following `reg_addr` combinationally.
- R3: Bits 15:10 of every register always read zero, and the values written to them are dropped.
- R4: A write to any offset outside the eight listed ones changes no register, and a read of such an offset returns 0x0000.
- R5: A write is blocked when `lock_in` is high at the same clock edge. Once `lock_in` has been sampled high, every later write is ignored until reset.
- R6: Let U be address bits 35:26. Rank n of the channel chosen by `dec_chan` (0 or 1) is selected when U is at least the boundary of rank n-1 (0 for rank 0) and less than the boundary of rank n. The lowest such rank wins. `cs[n]` is then the only bit set, one clock after the inputs are sampled.
- R7: When no rank matches, including any U at or above the rank 3 boundary, `miss` is 1 and `cs` is zero one clock later. Otherwise `miss` is 0.
- R8: A rank whose boundary equals the boundary of the rank below it is never selected.
- R9: A channel whose four boundaries are all zero gives a miss for every address.
- R10: Decoding uses only the registers of the channel chosen by `dec_chan`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_addr` |
| lock_in | input | 1 | Lock request, sticky once sampled |
| dec_addr | input | 36 | Physical address to decode |
| dec_chan | input | 1 | Channel the address belongs to |
| cs | output | 4 | One-hot rank chip select, registered |
| miss | output | 1 | Address falls in no rank, registered |

## Verification
The hardest case to reach from the ports is a boundary table that is not monotonic. In that case a later rank's window can open below an earlier rank's boundary, and only the lowest-match rule decides the outcome. The bench gets there by programming channel 1 with a falling boundary between ranks 0 and 1, and then sweeping unit indices across every edge. It also takes the register table through lock and then tries every kind of write. Read-back shows each write had no effect.

// File: rtl/rank_bound_dec.sv
module rank_bound_dec #(
  parameter int RANKS    = 4,
  parameter int BND_W    = 10,
  parameter int ADDR_W   = 36,
  parameter int UNIT_LSB = 26,
  parameter int OFS_W    = 12,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lock_in,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_chan,
  output logic [RANKS-1:0]  cs,
  output logic              miss
);
  localparam int CHANS = 2;
  localparam int RK_W  = $clog2(RANKS);
  localparam int SEL_W = RK_W + 1;
  localparam int U_W   = ADDR_W - UNIT_LSB;
  localparam int CMP_W = (U_W > BND_W) ? U_W : BND_W;
  localparam int TBL_W = CHANS * RANKS * BND_W;

  logic [TBL_W-1:0] bnd_q;
  logic             lock_q;
  logic             reg_map;
  logic [SEL_W-1:0] reg_sel;
  logic [CMP_W-1:0] unit;
  logic [RANKS-1:0] hit;
  logic             found;
  logic             unused_bits;

  assign reg_map = (reg_addr[OFS_W-1:11] == '0) && reg_addr[9] &&
                   (reg_addr[8:RK_W+1] == '0) && !reg_addr[0];
  assign reg_sel = {reg_addr[10], reg_addr[RK_W:1]};
  assign rd_data = reg_map ? DATA_W'(bnd_q[int'(reg_sel)*BND_W +: BND_W]) : '0;
  assign unit    = CMP_W'(dec_addr[ADDR_W-1:UNIT_LSB]);
  assign unused_bits = ^{wr_data[DATA_W-1:BND_W], dec_addr[UNIT_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else if (lock_in) lock_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bnd_q <= '0;
    else if (wr_en && reg_map && !lock_q && !lock_in)
      bnd_q[int'(reg_sel)*BND_W +: BND_W] <= wr_data[BND_W-1:0];
  end

  always_comb begin
    logic [CMP_W-1:0] lo, hi;
    hit   = '0;
    found = 1'b0;
    lo    = '0;
    for (int r = 0; r < RANKS; r++) begin
      hi = CMP_W'(bnd_q[(int'(dec_chan)*RANKS + r)*BND_W +: BND_W]);
      if (!found && unit >= lo && unit < hi) begin
        hit[r] = 1'b1;
        found  = 1'b1;
      end
      lo = hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs   <= '0;
      miss <= 1'b1;
    end else begin
      cs   <= hit;
      miss <= !found;
    end
  end
endmodule

// File: rtl/rank_bound_dec_chk.sv
module rank_bound_dec_chk #(
  parameter int RANKS  = 4,
  parameter int BND_W  = 10,
  parameter int OFS_W  = 12,
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        lock_q,
  input logic [2*RANKS*BND_W-1:0]    bnd_q,
  input logic [OFS_W-1:0]            reg_addr,
  input logic [DATA_W-1:0]           rd_data,
  input logic                        dec_chan,
  input logic [RANKS-1:0]            cs,
  input logic                        miss
);
  logic             map_ok;
  logic             chan_zero;
  logic [RANKS-1:0] rank_emp;

  always_comb begin
    map_ok = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < RANKS; r++)
        if (reg_addr == OFS_W'(32'h200 + c*32'h400 + r*2)) map_ok = 1'b1;
  end

  always_comb begin
    chan_zero = 1'b1;
    for (int r = 0; r < RANKS; r++) begin
      if (bnd_q[(int'(dec_chan)*RANKS + r)*BND_W +: BND_W] != '0) chan_zero = 1'b0;
      if (r == 0)
        rank_emp[r] = bnd_q[(int'(dec_chan)*RANKS)*BND_W +: BND_W] == '0;
      else
        rank_emp[r] = bnd_q[(int'(dec_chan)*RANKS + r)*BND_W +: BND_W] ==
                      bnd_q[(int'(dec_chan)*RANKS + r - 1)*BND_W +: BND_W];
    end
  end

  p_cs_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs) && (miss != (|cs)));

  p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (cs == '0));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);

  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> $stable(bnd_q));

  p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:BND_W] == '0);

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !map_ok |-> (rd_data == '0));

  p_unpop_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chan_zero) |-> miss);

  for (genvar g = 0; g < RANKS; g++) begin : g_emp
    p_empty_rank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs[g] |-> !$past(rank_emp[g]));
  end
endmodule

bind rank_bound_dec rank_bound_dec_chk #(
  .RANKS(RANKS), .BND_W(BND_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .bnd_q(bnd_q),
  .reg_addr(reg_addr), .rd_data(rd_data), .dec_chan(dec_chan),
  .cs(cs), .miss(miss)
);

// File: tb/rank_bound_dec_test.sv
module rank_bound_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        lock_in = 1'b0;
  logic [35:0] dec_addr = '0;
  logic        dec_chan = 1'b0;
  logic [3:0]  cs;
  logic        miss;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [9:0] sh [2][4];

  always #4 clk = ~clk;

  rank_bound_dec uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .lock_in(lock_in),
    .dec_addr(dec_addr), .dec_chan(dec_chan), .cs(cs), .miss(miss)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d, input logic lk);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1; lock_in = lk;
    @(negedge clk);
    wr_en = 1'b0; lock_in = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, 32'(rd_data), 32'(exp));
  endtask

  function automatic logic [11:0] ofs(input int c, input int r);
    return 12'(32'h200 + c*32'h400 + r*2);
  endfunction

  function automatic logic [4:0] model(input int c, input int u);
    int lo = 0;
    for (int r = 0; r < 4; r++) begin
      if (u >= lo && u < int'(sh[c][r])) return 5'(1 << r);
      lo = int'(sh[c][r]);
    end
    return 5'h10;
  endfunction

  task automatic dec_chk(input string req, input int c, input int u);
    logic [4:0] exp;
    @(negedge clk);
    dec_addr = {10'(u), 26'h2A5_5A5A};
    dec_chan = 1'(c);
    exp = model(c, u);
    @(negedge clk);
    chk(req, {27'b0, miss, cs}, {27'b0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cs", 32'(cs), 0);
    chk("R1 miss", 32'(miss), 1);
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) rd_chk("R1 reg", ofs(c, r), 16'h0);
  endtask

  task automatic t_program;
    logic [9:0] v0 [4] = '{10'd4, 10'd4, 10'd10, 10'd16};
    for (int r = 0; r < 4; r++) begin
      wr(ofs(0, r), {6'b0, v0[r]}, 1'b0);
      sh[0][r] = v0[r];
    end
    for (int r = 0; r < 4; r++) rd_chk("R2 readback", ofs(0, r), {6'b0, sh[0][r]});
  endtask

  task automatic t_unpop;
    dec_chk("R9 unpopulated ch1 u0", 1, 0);
    dec_chk("R9 unpopulated ch1 u5", 1, 5);
    dec_chk("R10 ch1 ignores ch0 u2", 1, 2);
  endtask

  task automatic t_decode;
    for (int u = 0; u < 18; u++) dec_chk("R6 ch0 sweep", 0, u);
    dec_chk("R7 at rank3 bound", 0, 16);
    dec_chk("R7 top unit", 0, 1023);
    dec_chk("R8 empty rank1 u4", 0, 4);
  endtask

  task automatic t_nonmono;
    logic [9:0] v1 [4] = '{10'd5, 10'd3, 10'd8, 10'd1023};
    for (int r = 0; r < 4; r++) begin
      wr(ofs(1, r), {6'b0, v1[r]}, 1'b0);
      sh[1][r] = v1[r];
    end
    for (int u = 0; u < 12; u++) dec_chk("R6 ch1 lowest wins", 1, u);
    dec_chk("R7 ch1 u1023", 1, 1023);
    dec_chk("R6 ch1 u1022", 1, 1022);
    dec_chk("R10 ch0 after ch1 program", 0, 12);
  endtask

  task automatic t_reserved;
    wr(ofs(0, 2), 16'hFC0B, 1'b0);
    sh[0][2] = 10'h00B;
    rd_chk("R3 reserved dropped", ofs(0, 2), 16'h000B);
    dec_chk("R3 new boundary u10", 0, 10);
  endtask

  task automatic t_unmapped;
    logic [11:0] bad [5] = '{12'h201, 12'h208, 12'h400, 12'hA00, 12'h000};
    for (int i = 0; i < 5; i++) wr(bad[i], 16'h03FF, 1'b0);
    for (int i = 0; i < 5; i++) rd_chk("R4 unmapped read", bad[i], 16'h0);
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) rd_chk("R4 table unchanged", ofs(c, r), {6'b0, sh[c][r]});
  endtask

  task automatic t_lock;
    wr(ofs(0, 0), 16'h0002, 1'b1);
    rd_chk("R5 write with lock edge", ofs(0, 0), {6'b0, sh[0][0]});
    wr(ofs(0, 3), 16'h0001, 1'b0);
    rd_chk("R5 sticky lock", ofs(0, 3), {6'b0, sh[0][3]});
    wr(ofs(1, 1), 16'h0000, 1'b0);
    rd_chk("R5 sticky lock ch1", ofs(1, 1), {6'b0, sh[1][1]});
    dec_chk("R5 decode after lock", 0, 12);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) sh[c][r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_program;
    t_unpop;
    t_decode;
    t_nonmono;
    t_reserved;
    t_unmapped;
    t_lock;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule